// File: doc/BRIEF.md
# Descriptor-Ring Memory Copy Engine

This block copies data from one place in memory to another. Software builds the work list as two rings of descriptors that sit side by side in memory. Each slot of the source ring gives a source address and a byte count. The slot with the same position in the destination ring gives the target address. Software programs each ring's base address and its power-of-two slot count through a small register port. It then hands work over by moving the source ring's software index forward. The engine owns a second index per ring. Every slot between its own source index and the software index counts as pending.

For each pending slot the engine reads three descriptor words and then copies the payload one 32-bit word at a time. The copy runs over a single memory port with a request/grant handshake and a separate read-response strobe. When the last word has been written, the engine writes the length and a completion flag back into the destination descriptor. It then steps both of its ring indices. A global register controls the engine: two enables, two read-only busy flags, and stored fields for burst size and mode. A reset register can hold either ring's engine index at zero.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset every register reads as zero and the memory port issues no request.
- R2: While both enables (global bits 0 and 2) are set and the source engine index differs from the source software index, the engine copies the descriptor's words from the source address to the destination address in ascending order. The address and control of a descriptor slot are the words at ring base + 16·index and ring base + 16·index + 4.
- R3: The byte length is bits 29:16 of the source descriptor's control word. It is rounded up to whole 4-byte words, and no other word in the destination area is written. A length of zero copies nothing but still completes the slot.
- R4: On completion, the destination descriptor's control word is written as length<<16. The flag bit DONE_BIT (default 31) is ORed in when global bit 6 is set, and omitted when bit 6 is clear.
- R5: After the completion write, the source and destination engine indices (offsets 0x00C and 0x10C) each advance by one and wrap by masking with the ring count minus one.
- R6: The engine does not start a slot while the destination engine index equals the destination software index (offset 0x108). It starts once software moves that index away.
- R7: With either enable clear, no new slot is started, but a slot already under way is completed. Global bits 1 and 3 read 1 exactly while a slot is being processed.
- R8: Reset-register bit 0 forces the source engine index to zero, and bit 16 forces the destination engine index to zero, each without affecting the other ring.
- R9: Registers sit at 0x000/0x004/0x008/0x00C (source base, count, software index, engine index), at 0x100 to 0x10C for the destination ring, at 0x204 (global) and at 0x208 (reset). The global register's writable bits 0, 2, 5:4, 6 and 10 read back as written, and the engine indices may be written directly.
- R10: A memory request holds its address, write flag and data until it is granted. No new request is raised while a read response is still awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions take for granted that software leaves the index and reset registers alone while a slot is in flight. They also assume ring counts are powers of two and lengths stay within the 0x3F80-byte limit, and that memory returns exactly one response per granted read. The stimulus keeps to this. It uses a four-slot ring, keeps every batch to at most three slots behind the reserved destination slot, and writes engine indices and reset bits only while the engine is idle. The memory model stalls grants pseudo-randomly, so that held requests and back-to-back reads are both exercised.

// File: rtl/rce_pkg.sv
package rce_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC_A,
    ST_SRC_L,
    ST_DST_A,
    ST_DATA_RD,
    ST_DATA_WR,
    ST_DONE_WR
  } eng_state_e;

  localparam int LEN_LSB  = 16;
  localparam int LEN_W    = 14;
  localparam int WORDS_W  = LEN_W - 1;

  // whole 32-bit words needed for a byte count
  function automatic logic [WORDS_W-1:0] len_to_words(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] sum;
    sum = {1'b0, len} + (LEN_W+1)'(3);
    return sum[LEN_W:2];
  endfunction

  // byte address of a ring slot (16-byte slots)
  function automatic logic [31:0] slot_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + (idx << 4);
  endfunction

endpackage

// File: rtl/rce_regs.sv
module rce_regs #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [11:0]      addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             busy,
  input  logic             adv,
  output logic [31:0]      tx_base,
  output logic [31:0]      rx_base,
  output logic [IDX_W-1:0] tx_cpu,
  output logic [IDX_W-1:0] rx_cpu,
  output logic [IDX_W-1:0] tx_dma,
  output logic [IDX_W-1:0] rx_dma,
  output logic             en_src,
  output logic             en_dst,
  output logic             done_wb_en
);
  localparam int          CNT_W      = IDX_W + 1;
  localparam logic [31:0] GLOB_WMASK = 32'h0000_0475;

  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [31:0]      glob_q;
  logic             rst_src, rst_dst;
  logic [IDX_W-1:0] tx_mask, rx_mask;

  assign tx_mask = IDX_W'(tx_cnt - CNT_W'(1));
  assign rx_mask = IDX_W'(rx_cnt - CNT_W'(1));

  logic wr_txb, wr_txc, wr_txcpu, wr_txdma;
  logic wr_rxb, wr_rxc, wr_rxcpu, wr_rxdma, wr_glob, wr_rst;
  assign wr_txb   = wr_en && addr == 12'h000;
  assign wr_txc   = wr_en && addr == 12'h004;
  assign wr_txcpu = wr_en && addr == 12'h008;
  assign wr_txdma = wr_en && addr == 12'h00C;
  assign wr_rxb   = wr_en && addr == 12'h100;
  assign wr_rxc   = wr_en && addr == 12'h104;
  assign wr_rxcpu = wr_en && addr == 12'h108;
  assign wr_rxdma = wr_en && addr == 12'h10C;
  assign wr_glob  = wr_en && addr == 12'h204;
  assign wr_rst   = wr_en && addr == 12'h208;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_base <= '0; rx_base <= '0; tx_cnt <= '0; rx_cnt <= '0;
      tx_cpu  <= '0; rx_cpu  <= '0; glob_q <= '0;
      rst_src <= 1'b0; rst_dst <= 1'b0;
    end else begin
      if (wr_txb)   tx_base <= wdata;
      if (wr_rxb)   rx_base <= wdata;
      if (wr_txc)   tx_cnt  <= wdata[CNT_W-1:0];
      if (wr_rxc)   rx_cnt  <= wdata[CNT_W-1:0];
      if (wr_txcpu) tx_cpu  <= wdata[IDX_W-1:0];
      if (wr_rxcpu) rx_cpu  <= wdata[IDX_W-1:0];
      if (wr_glob)  glob_q  <= wdata & GLOB_WMASK;
      if (wr_rst) begin
        rst_src <= wdata[0];
        rst_dst <= wdata[16];
      end
    end
  end

  // engine-owned indices: reset bit first, then software write, then advance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_dma <= '0;
      rx_dma <= '0;
    end else begin
      if (rst_src)       tx_dma <= '0;
      else if (wr_txdma) tx_dma <= wdata[IDX_W-1:0];
      else if (adv)      tx_dma <= (tx_dma + IDX_W'(1)) & tx_mask;
      if (rst_dst)       rx_dma <= '0;
      else if (wr_rxdma) rx_dma <= wdata[IDX_W-1:0];
      else if (adv)      rx_dma <= (rx_dma + IDX_W'(1)) & rx_mask;
    end
  end

  assign en_src     = glob_q[0];
  assign en_dst     = glob_q[2];
  assign done_wb_en = glob_q[6];

  always_comb begin
    unique case (addr)
      12'h000: rdata = tx_base;
      12'h004: rdata = 32'(tx_cnt);
      12'h008: rdata = 32'(tx_cpu);
      12'h00C: rdata = 32'(tx_dma);
      12'h100: rdata = rx_base;
      12'h104: rdata = 32'(rx_cnt);
      12'h108: rdata = 32'(rx_cpu);
      12'h10C: rdata = 32'(rx_dma);
      12'h204: rdata = glob_q | {28'b0, busy, 1'b0, busy, 1'b0};
      12'h208: rdata = {15'b0, rst_dst, 15'b0, rst_src};
      default: rdata = '0;
    endcase
  end

  // R8: reset bits pin the engine indices to zero
  a_r8_src_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    rst_src |=> tx_dma == '0);
  a_r8_dst_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    rst_dst |=> rx_dma == '0);
  // R5: an index moves only on an advance, a write or a reset bit
  a_r5_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_txdma && !rst_src) |=> $stable(tx_dma));
  // R5: an advance moves each index by exactly one slot in its ring
  a_r5_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_txdma && !rst_src && !wr_txc) |=>
      ((tx_dma - $past(tx_dma)) & tx_mask) == (IDX_W'(1) & tx_mask));

endmodule

// File: rtl/rce_engine.sv
module rce_engine
  import rce_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int DONE_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_src,
  input  logic             en_dst,
  input  logic             done_wb_en,
  input  logic [31:0]      tx_base,
  input  logic [31:0]      rx_base,
  input  logic [IDX_W-1:0] tx_cpu,
  input  logic [IDX_W-1:0] tx_dma,
  input  logic [IDX_W-1:0] rx_cpu,
  input  logic [IDX_W-1:0] rx_dma,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             adv
);
  eng_state_e         state_q;
  logic               wait_q;
  logic [31:0]        src_ptr_q, dst_ptr_q, data_q;
  logic [LEN_W-1:0]   len_q;
  logic [WORDS_W-1:0] words_q;

  logic        start, acc, rd_done;
  logic [31:0] src_desc, dst_desc, done_word;

  assign src_desc = slot_addr(tx_base, 32'(tx_dma));
  assign dst_desc = slot_addr(rx_base, 32'(rx_dma));
  assign start    = state_q == ST_IDLE && en_src && en_dst &&
                    tx_cpu != tx_dma && rx_cpu != rx_dma;
  assign mem_req  = state_q != ST_IDLE && !wait_q;
  assign mem_we   = state_q == ST_DATA_WR || state_q == ST_DONE_WR;
  assign acc      = mem_req && mem_gnt;
  assign rd_done  = wait_q && mem_rvalid;
  assign busy     = state_q != ST_IDLE;
  assign adv      = state_q == ST_DONE_WR && acc;

  always_comb begin
    done_word = 32'(len_q) << LEN_LSB;
    if (done_wb_en) done_word[DONE_BIT] = 1'b1;
  end

  always_comb begin
    mem_wdata = '0;
    unique case (state_q)
      ST_SRC_A:   mem_addr = src_desc;
      ST_SRC_L:   mem_addr = src_desc + 32'd4;
      ST_DST_A:   mem_addr = dst_desc;
      ST_DATA_RD: mem_addr = src_ptr_q;
      ST_DATA_WR: begin mem_addr = dst_ptr_q; mem_wdata = data_q; end
      ST_DONE_WR: begin mem_addr = dst_desc + 32'd4; mem_wdata = done_word; end
      default:    mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wait_q    <= 1'b0;
      src_ptr_q <= '0;
      dst_ptr_q <= '0;
      data_q    <= '0;
      len_q     <= '0;
      words_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_SRC_A;
        ST_SRC_A, ST_SRC_L, ST_DST_A, ST_DATA_RD: begin
          if (acc) wait_q <= 1'b1;
          if (rd_done) begin
            wait_q <= 1'b0;
            unique case (state_q)
              ST_SRC_A: begin
                src_ptr_q <= mem_rdata;
                state_q   <= ST_SRC_L;
              end
              ST_SRC_L: begin
                len_q   <= mem_rdata[LEN_LSB +: LEN_W];
                words_q <= len_to_words(mem_rdata[LEN_LSB +: LEN_W]);
                state_q <= ST_DST_A;
              end
              ST_DST_A: begin
                dst_ptr_q <= mem_rdata;
                state_q   <= (words_q == '0) ? ST_DONE_WR : ST_DATA_RD;
              end
              default: begin
                data_q  <= mem_rdata;
                state_q <= ST_DATA_WR;
              end
            endcase
          end
        end
        ST_DATA_WR: if (acc) begin
          src_ptr_q <= src_ptr_q + 32'd4;
          dst_ptr_q <= dst_ptr_q + 32'd4;
          words_q   <= words_q - WORDS_W'(1);
          state_q   <= (words_q == WORDS_W'(1)) ? ST_DONE_WR : ST_DATA_RD;
        end
        ST_DONE_WR: if (acc) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: a stalled request keeps its payload
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R10: nothing new goes out while a read is outstanding
  a_r10_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> !mem_req);
  // R7: a slot is only begun while both directions are enabled
  a_r7_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_IDLE && state_q != ST_IDLE) |-> $past(en_src && en_dst));
  // R6: the reserved destination slot is never begun
  a_r6_reserved_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_IDLE && state_q != ST_IDLE) |-> $past(rx_cpu != rx_dma));
  // R3: completion is written only after every payload word has been moved
  a_r3_words_drained: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_DONE_WR |-> words_q == '0);

endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine #(
  parameter int IDX_W    = 8,
  parameter int DONE_BIT = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [31:0]      tx_base, rx_base;
  logic [IDX_W-1:0] tx_cpu, rx_cpu, tx_dma, rx_dma;
  logic             en_src, en_dst, done_wb_en, busy, adv;

  rce_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .busy(busy), .adv(adv),
    .tx_base(tx_base), .rx_base(rx_base),
    .tx_cpu(tx_cpu), .rx_cpu(rx_cpu), .tx_dma(tx_dma), .rx_dma(rx_dma),
    .en_src(en_src), .en_dst(en_dst), .done_wb_en(done_wb_en)
  );

  rce_engine #(.IDX_W(IDX_W), .DONE_BIT(DONE_BIT)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .en_src(en_src), .en_dst(en_dst), .done_wb_en(done_wb_en),
    .tx_base(tx_base), .rx_base(rx_base),
    .tx_cpu(tx_cpu), .tx_dma(tx_dma), .rx_cpu(rx_cpu), .rx_dma(rx_dma),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .adv(adv)
  );

  // R1: no memory traffic straight out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !mem_req);

endmodule

// File: tb/ring_copy_engine_tb.sv
module ring_copy_engine_tb;
  localparam logic [31:0] SRC_RING = 32'h0400;
  localparam logic [31:0] DST_RING = 32'h0800;
  localparam logic [31:0] SRC_DATA = 32'h1000;
  localparam logic [31:0] DST_DATA = 32'h2000;
  localparam logic [31:0] FILL     = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:4095];
  logic [7:0]  lfsr = 8'h5B;
  int          viol = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int txc = 0;

  always #5 clk = ~clk;

  ring_copy_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  assign mem_gnt = lfsr[0] | lfsr[3];

  // memory model with pseudo-random grant stalls and a one-cycle read response
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[13:2]];
      end
    end
    if (rst_n && prev_stall && (!mem_req || mem_addr != prev_addr)) viol <= viol + 1;
    prev_stall <= mem_req && !mem_gnt;
    prev_addr  <= mem_addr;
  end

  function automatic logic [31:0] pat(input int seed, input int k);
    return {16'(seed), 16'(k)} ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic prep(input int slot, input int len, input int seed);
    for (int k = 0; k < 64; k++) begin
      mem[(SRC_DATA >> 2) + slot*64 + k] = pat(seed, k);
      mem[(DST_DATA >> 2) + slot*64 + k] = FILL;
    end
    mem[(SRC_RING >> 2) + slot*4]     = SRC_DATA + 32'(slot*256);
    mem[(SRC_RING >> 2) + slot*4 + 1] = (32'(len) << 16) | 32'h4000_0000;
    mem[(DST_RING >> 2) + slot*4]     = DST_DATA + 32'(slot*256);
    mem[(DST_RING >> 2) + slot*4 + 1] = 32'h0;
  endtask

  task automatic kick(input int n);
    txc = (txc + n) & 3;
    wr(12'h008, 32'(txc));
  endtask

  task automatic wait_idx(input int target, input string req);
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(12'h00C, v);
      if (v == 32'(target)) break;
    end
    check(v == 32'(target), req, v, 32'(target));
  endtask

  task automatic verify(input int slot, input int len, input int seed, input bit flag, input string req);
    int words = (len + 3) / 4;
    int bad = 0;
    logic [31:0] first_act = '0, first_exp = '0, exp, dw;
    for (int k = 0; k < 64; k++) begin
      exp = (k < words) ? pat(seed, k) : FILL;
      if (mem[(DST_DATA >> 2) + slot*64 + k] !== exp) begin
        if (bad == 0) begin first_act = mem[(DST_DATA >> 2) + slot*64 + k]; first_exp = exp; end
        bad++;
      end
    end
    check(bad == 0, req, first_act, first_exp);
    exp = (32'(len) << 16) | (flag ? 32'h8000_0000 : 32'h0);
    dw  = mem[(DST_RING >> 2) + slot*4 + 1];
    check(dw === exp, "R4", dw, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(mem_req == 1'b0, "R1", 32'(mem_req), 0);
    rd(12'h000, v); check(v == 0, "R1", v, 0);
    rd(12'h00C, v); check(v == 0, "R1", v, 0);
    rd(12'h10C, v); check(v == 0, "R1", v, 0);
    rd(12'h204, v); check(v == 0, "R1", v, 0);
    rd(12'h208, v); check(v == 0, "R1", v, 0);

    // R9: setup and global readback
    wr(12'h000, SRC_RING); wr(12'h004, 4);
    wr(12'h100, DST_RING); wr(12'h104, 4);
    wr(12'h108, 3);
    wr(12'h204, 32'hFFFF_FFFF);
    rd(12'h204, v); check(v == 32'h475, "R9", v, 32'h475);
    wr(12'h204, 32'h465);
    rd(12'h004, v); check(v == 4, "R9", v, 4);

    // R2/R3: three slots, lengths 4, 1, 7
    prep(0, 4, 11); prep(1, 1, 12); prep(2, 7, 13);
    kick(3);
    wait_idx(3, "R2");
    verify(0, 4, 11, 1, "R2");
    verify(1, 1, 12, 1, "R3");
    verify(2, 7, 13, 1, "R3");
    rd(12'h10C, v); check(v == 3, "R5", v, 3);

    // R5: wrap with a zero-length slot and a full 64-word slot
    wr(12'h108, 2);
    prep(3, 0, 14); prep(0, 256, 15);
    kick(2);
    wait_idx(1, "R5");
    verify(3, 0, 14, 1, "R3");
    verify(0, 256, 15, 1, "R2");
    rd(12'h10C, v); check(v == 1, "R5", v, 1);

    // R6: reserved destination slot blocks; R4 with flag writeback off
    wr(12'h108, 1);
    wr(12'h204, 32'h425);
    prep(1, 8, 16);
    kick(1);
    repeat (300) @(negedge clk);
    rd(12'h00C, v); check(v == 1, "R6", v, 1);
    check(mem[(DST_DATA >> 2) + 64] == FILL, "R6", mem[(DST_DATA >> 2) + 64], FILL);
    rd(12'h204, v); check((v & 32'hA) == 0, "R7", v & 32'hA, 0);
    wr(12'h108, 0);
    wait_idx(2, "R6");
    verify(1, 8, 16, 0, "R4");
    wr(12'h204, 32'h465);

    // R7: disabled engine starts nothing, busy while running
    wr(12'h108, 1);
    wr(12'h204, 32'h460);
    prep(2, 200, 17);
    kick(1);
    repeat (300) @(negedge clk);
    rd(12'h00C, v); check(v == 2, "R7", v, 2);
    wr(12'h204, 32'h465);
    repeat (4) @(negedge clk);
    rd(12'h204, v); check((v & 32'hA) == 32'hA, "R7", v & 32'hA, 32'hA);
    wait_idx(3, "R7");
    verify(2, 200, 17, 1, "R7");
    rd(12'h204, v); check(v == 32'h465, "R7", v, 32'h465);

    // R7: disabling mid-slot lets the slot finish but starts no other
    prep(3, 256, 18);
    kick(1);
    repeat (10) @(negedge clk);
    wr(12'h204, 32'h460);
    wait_idx(0, "R7");
    verify(3, 256, 18, 1, "R7");
    prep(0, 4, 19);
    kick(1);
    repeat (300) @(negedge clk);
    rd(12'h00C, v); check(v == 0, "R7", v, 0);
    rd(12'h204, v); check(v == 32'h460, "R7", v, 32'h460);

    // R8/R9: direct index writes and per-ring reset bits
    wr(12'h00C, 2);
    rd(12'h00C, v); check(v == 2, "R9", v, 2);
    wr(12'h10C, 1);
    wr(12'h208, 32'h1);
    rd(12'h00C, v); check(v == 0, "R8", v, 0);
    rd(12'h10C, v); check(v == 1, "R8", v, 1);
    wr(12'h208, 32'h1_0000);
    rd(12'h10C, v); check(v == 0, "R8", v, 0);
    rd(12'h208, v); check(v == 32'h1_0000, "R8", v, 32'h1_0000);
    wr(12'h208, 0);

    // R10: request stability seen by the memory model
    check(viol == 0, "R10", 32'(viol), 0);

    summary();
  end

endmodule